// File: doc/BRIEF.md
# Branch Target and Fetch Counter Unit

This unit produces the next program fetch address for a core that issues instructions in execute packets of several slots. Each slot can hold one of three control-flow operations: a branch whose target is a signed word displacement added to the base of the fetch packet holding it, a branch that jumps to a 32-bit register value, and a return-address setup that writes "packet base plus a short signed word offset" to a destination register and then holds issue for a small number of empty cycles. Offsets are taken from the packet base, not from the slot that holds the operation. The encoded displacement is therefore (target minus packet base) divided by four.

A packet is offered with `pkt_vld`. It is accepted in any cycle where the unit is not stalling. The fetch counter, destination result and flag outputs are registered, so they appear in the cycle after acceptance. A small two-state sequencer handles the stall. In state `ST_ISSUE` packets are accepted. The transition `ISSUE_TO_HOLD` is taken when an accepted return setup carries a nonzero count. In state `ST_HOLD` one cycle of the count is spent per clock, and the transition `HOLD_TO_ISSUE` is taken when the last cycle is spent. When more than one branch in a packet is taken, the unit raises a flag and keeps the target of the lowest-numbered taken branch slot, so the outcome does not depend on chance.

Top module: `fetch_ctr_unit`

## Requirements
- R1: After an accepted packet whose lowest taken branch is a displacement branch (slot op code 1, displacement in imm[20:0]), `fetch_ctr` equals the aligned packet base plus the sign-extended 21-bit displacement times four, and `redirect` is 1 for that cycle.
- R2: After an accepted packet whose lowest taken branch is a register branch (slot op code 2), `fetch_ctr` equals that slot's 32-bit `slot_reg` value and `redirect` is 1.
- R3: An accepted taken return setup (slot op code 3, offset in imm[6:0]) gives `dst_wr`=1 and `dst_val` = aligned base plus the sign-extended 7-bit offset times four in the next cycle. When several slots hold a return setup, the lowest-numbered slot is used.
- R4: The return setup's count in imm[9:7] (0 to 7) makes `stall` high for exactly that many cycles, starting in the cycle after acceptance. A count of 0 gives no stall.
- R5: While `stall` is high, `pkt_vld` is ignored: no `redirect`, no `dst_wr`, and `fetch_ctr` is unchanged.
- R6: The low 5 bits of `pkt_base` are treated as zero.
- R7: A slot with op code 0 or with `slot_taken` low has no effect on any output.
- R8: When two or more branch slots are taken in one accepted packet, `dual_br` is 1 in the next cycle, together with `redirect`, and `fetch_ctr` takes the target of the lowest-numbered taken branch slot.
- R9: After reset, `fetch_ctr` is RESET_PC (0), `dst_val` is 0, and `redirect`, `dst_wr`, `dual_br` and `stall` are 0.
- R10: `fetch_ctr` changes only in a cycle where `redirect` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_vld | input | 1 | Execute packet offered this cycle |
| pkt_base | input | ADDR_W | Address of the containing fetch packet |
| slot_op | input | 2*SLOTS | Per-slot op code: 0 none, 1 displacement branch, 2 register branch, 3 return setup |
| slot_taken | input | SLOTS | Per-slot condition result |
| slot_imm | input | IMM_W*SLOTS | Per-slot constant field |
| slot_reg | input | ADDR_W*SLOTS | Per-slot register operand |
| fetch_ctr | output | ADDR_W | Program fetch counter |
| redirect | output | 1 | Fetch counter was loaded this cycle |
| dst_wr | output | 1 | Destination result valid |
| dst_val | output | ADDR_W | Return-address result |
| stall | output | 1 | Issue is held for empty cycles |
| dual_br | output | 1 | More than one taken branch seen in a packet |

## Verification
The bench builds the unit with its default parameters: two slots, 32-bit addresses, a 21-bit branch field, a 7-bit return offset and a 3-bit count. With two slots, every pairing of the four op codes with both condition values can be covered, which reaches every priority and double-branch case. The 7-bit offset and the 3-bit count are small enough to sweep through every value. The 21-bit displacement is covered by its extremes plus a strided walk through its range, with packet bases that have nonzero low bits.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_BDISP = 2'd1,
        OP_BREG  = 2'd2,
        OP_RETK  = 2'd3
    } slot_op_e;

    typedef enum logic {
        ST_ISSUE = 1'b0,
        ST_HOLD  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fbt_slot_calc.sv
module fbt_slot_calc
    import fbt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BDISP_W = 21,
    parameter int RDISP_W = 7,
    parameter int NOP_W   = 3,
    parameter int IMM_W   = 21
) (
    input  logic [ADDR_W-1:0] base_al,
    input  slot_op_e          op,
    input  logic              taken,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] rval,
    output logic              is_br,
    output logic [ADDR_W-1:0] br_tgt,
    output logic              is_ret,
    output logic [ADDR_W-1:0] ret_val,
    output logic [NOP_W-1:0]  ret_nop
);

    localparam int BPAD = ADDR_W - BDISP_W - 2;
    localparam int RPAD = ADDR_W - RDISP_W - 2;

    logic [ADDR_W-1:0] bdisp_ext;
    logic [ADDR_W-1:0] rdisp_ext;

    always_comb begin
        bdisp_ext = {{BPAD{imm[BDISP_W-1]}}, imm[BDISP_W-1:0], 2'b00};
        rdisp_ext = {{RPAD{imm[RDISP_W-1]}}, imm[RDISP_W-1:0], 2'b00};
        is_br     = taken && (op == OP_BDISP || op == OP_BREG);
        is_ret    = taken && (op == OP_RETK);
        br_tgt    = (op == OP_BREG) ? rval : base_al + bdisp_ext;
        ret_val   = base_al + rdisp_ext;
        ret_nop   = imm[RDISP_W +: NOP_W];
    end

endmodule

// File: rtl/fbt_pick.sv
module fbt_pick #(
    parameter int SLOTS  = 2,
    parameter int ADDR_W = 32,
    parameter int NOP_W  = 3
) (
    input  logic              is_br   [SLOTS],
    input  logic [ADDR_W-1:0] br_tgt  [SLOTS],
    input  logic              is_ret  [SLOTS],
    input  logic [ADDR_W-1:0] ret_val [SLOTS],
    input  logic [NOP_W-1:0]  ret_nop [SLOTS],
    output logic              br_any,
    output logic              br_multi,
    output logic [ADDR_W-1:0] br_sel,
    output logic              ret_any,
    output logic [ADDR_W-1:0] ret_sel,
    output logic [NOP_W-1:0]  nop_sel
);

    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] br_cnt;

    always_comb begin
        br_cnt  = '0;
        br_any  = 1'b0;
        br_sel  = '0;
        ret_any = 1'b0;
        ret_sel = '0;
        nop_sel = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (is_br[i]) begin
                br_any = 1'b1;
                br_sel = br_tgt[i];
                br_cnt = br_cnt + 1'b1;
            end
            if (is_ret[i]) begin
                ret_any = 1'b1;
                ret_sel = ret_val[i];
                nop_sel = ret_nop[i];
            end
        end
        br_multi = br_cnt > CNT_W'(1);
    end

endmodule

// File: rtl/fbt_nop_seq.sv
module fbt_nop_seq
    import fbt_pkg::*;
#(
    parameter int NOP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NOP_W-1:0] load_n,
    output logic             stall
);

    seq_state_e       state_q, state_d;
    logic [NOP_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ISSUE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                if (load && load_n != '0) begin
                    state_d = ST_HOLD;
                    cnt_d   = load_n;
                end
            end
            ST_HOLD: begin
                stall = 1'b1;
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == NOP_W'(1)) begin
                    state_d = ST_ISSUE;
                end
            end
            default: begin
                state_d = ST_ISSUE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_ctr_unit.sv
module fetch_ctr_unit
    import fbt_pkg::*;
#(
    parameter int          SLOTS     = 2,
    parameter int          ADDR_W    = 32,
    parameter int          BDISP_W   = 21,
    parameter int          RDISP_W   = 7,
    parameter int          NOP_W     = 3,
    parameter int          ALIGN_LSB = 5,
    parameter int          IMM_W     = (BDISP_W > RDISP_W + NOP_W) ? BDISP_W : RDISP_W + NOP_W,
    parameter logic [31:0] RESET_PC  = 32'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pkt_vld,
    input  logic [ADDR_W-1:0]       pkt_base,
    input  logic [2*SLOTS-1:0]      slot_op,
    input  logic [SLOTS-1:0]        slot_taken,
    input  logic [IMM_W*SLOTS-1:0]  slot_imm,
    input  logic [ADDR_W*SLOTS-1:0] slot_reg,
    output logic [ADDR_W-1:0]       fetch_ctr,
    output logic                    redirect,
    output logic                    dst_wr,
    output logic [ADDR_W-1:0]       dst_val,
    output logic                    stall,
    output logic                    dual_br
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

    logic [ADDR_W-1:0] base_al;
    logic              is_br   [SLOTS];
    logic [ADDR_W-1:0] br_tgt  [SLOTS];
    logic              is_ret  [SLOTS];
    logic [ADDR_W-1:0] ret_val [SLOTS];
    logic [NOP_W-1:0]  ret_nop [SLOTS];
    logic              br_any, br_multi, ret_any;
    logic [ADDR_W-1:0] br_sel, ret_sel;
    logic [NOP_W-1:0]  nop_sel;
    logic              accept;

    assign base_al = pkt_base & ALIGN_MASK;
    assign accept  = pkt_vld && !stall;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        fbt_slot_calc #(
            .ADDR_W (ADDR_W),
            .BDISP_W(BDISP_W),
            .RDISP_W(RDISP_W),
            .NOP_W  (NOP_W),
            .IMM_W  (IMM_W)
        ) u_calc (
            .base_al(base_al),
            .op     (slot_op_e'(slot_op[2*g +: 2])),
            .taken  (slot_taken[g]),
            .imm    (slot_imm[IMM_W*g +: IMM_W]),
            .rval   (slot_reg[ADDR_W*g +: ADDR_W]),
            .is_br  (is_br[g]),
            .br_tgt (br_tgt[g]),
            .is_ret (is_ret[g]),
            .ret_val(ret_val[g]),
            .ret_nop(ret_nop[g])
        );
    end

    fbt_pick #(
        .SLOTS (SLOTS),
        .ADDR_W(ADDR_W),
        .NOP_W (NOP_W)
    ) u_pick (
        .is_br   (is_br),
        .br_tgt  (br_tgt),
        .is_ret  (is_ret),
        .ret_val (ret_val),
        .ret_nop (ret_nop),
        .br_any  (br_any),
        .br_multi(br_multi),
        .br_sel  (br_sel),
        .ret_any (ret_any),
        .ret_sel (ret_sel),
        .nop_sel (nop_sel)
    );

    fbt_nop_seq #(
        .NOP_W(NOP_W)
    ) u_nop (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && ret_any),
        .load_n(nop_sel),
        .stall (stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ctr <= RESET_PC[ADDR_W-1:0];
            redirect  <= 1'b0;
            dst_wr    <= 1'b0;
            dst_val   <= '0;
            dual_br   <= 1'b0;
        end else begin
            redirect <= accept && br_any;
            dst_wr   <= accept && ret_any;
            dual_br  <= accept && br_multi;
            if (accept && br_any) begin
                fetch_ctr <= br_sel;
            end
            if (accept && ret_any) begin
                dst_val <= ret_sel;
            end
        end
    end

endmodule

// File: rtl/fbt_chk.sv
module fbt_chk #(
    parameter int ADDR_W = 32,
    parameter int NOP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_ctr,
    input logic              redirect,
    input logic              dst_wr,
    input logic              stall,
    input logic              dual_br,
    input logic [NOP_W-1:0]  hold_cnt
);

    AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fetch_ctr) |-> redirect); // R10

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!redirect && !dst_wr)); // R5

    AST_DUAL_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        dual_br |-> redirect); // R8

    AST_STALL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && hold_cnt > NOP_W'(1)) |=> stall); // R4

endmodule

bind fetch_ctr_unit fbt_chk #(
    .ADDR_W(ADDR_W),
    .NOP_W (NOP_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_ctr(fetch_ctr),
    .redirect (redirect),
    .dst_wr   (dst_wr),
    .stall    (stall),
    .dual_br  (dual_br),
    .hold_cnt (u_nop.cnt_q)
);

// File: tb/fetch_ctr_unit_tb_top.sv
module fetch_ctr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_vld = 1'b0;
    logic [31:0] pkt_base = '0;
    logic [3:0]  slot_op = '0;
    logic [1:0]  slot_taken = '0;
    logic [41:0] slot_imm = '0;
    logic [63:0] slot_reg = '0;
    logic [31:0] fetch_ctr, dst_val;
    logic        redirect, dst_wr, stall, dual_br;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    fetch_ctr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .pkt_base(pkt_base),
        .slot_op(slot_op), .slot_taken(slot_taken), .slot_imm(slot_imm),
        .slot_reg(slot_reg), .fetch_ctr(fetch_ctr), .redirect(redirect),
        .dst_wr(dst_wr), .dst_val(dst_val), .stall(stall), .dual_br(dual_br)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one packet before the edge, sample 2 ns after it
    task automatic step(input logic vld);
        @(negedge clk);
        pkt_vld = vld;
        @(posedge clk);
        #2;
        pkt_vld = 1'b0;
    endtask

    function automatic logic [31:0] bdisp(input logic [31:0] base, input logic [20:0] d);
        logic signed [31:0] s;
        s = $signed({{11{d[20]}}, d});
        return (base & 32'hFFFF_FFE0) + 32'(s * 4);
    endfunction

    function automatic logic [31:0] rdisp(input logic [31:0] base, input logic [6:0] d);
        logic signed [31:0] s;
        s = $signed({{25{d[6]}}, d});
        return (base & 32'hFFFF_FFE0) + 32'(s * 4);
    endfunction

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] fc_prev;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 fetch_ctr", fetch_ctr, 32'h0);
        chk("R9 redirect", {31'b0, redirect}, 32'h0);
        chk("R9 dst_wr", {31'b0, dst_wr}, 32'h0);
        chk("R9 dst_val", dst_val, 32'h0);
        chk("R9 stall", {31'b0, stall}, 32'h0);
        chk("R9 dual_br", {31'b0, dual_br}, 32'h0);
        fc_prev = 32'h0;

        // R1 R2 R3 R7 R8: every op pairing with every taken combination
        for (int o0 = 0; o0 < 4; o0++) begin
            for (int o1 = 0; o1 < 4; o1++) begin
                for (int t = 0; t < 4; t++) begin
                    logic [31:0] base, tg [2], rv [2];
                    logic [20:0] im [2];
                    logic        isb [2], isr [2];
                    logic [31:0] efc, edst;
                    int          nb;
                    logic [1:0]  op [2];
                    base = 32'h1000_0000 + 32'((o0 * 16 + o1 * 4 + t) * 96 + 7);
                    op[0] = 2'(o0);
                    op[1] = 2'(o1);
                    im[0] = 21'(32'h0001_2345 + o1 * 64);
                    im[1] = 21'(32'h0010_0005 + o0 * 8);
                    im[0][9:7] = 3'b000;
                    im[1][9:7] = 3'b000;
                    rv[0] = 32'hA000_0000 + 32'(t * 16);
                    rv[1] = 32'hB000_0004 + 32'(o0 * 16);
                    nb = 0;
                    efc = fc_prev;
                    edst = 32'hxxxx_xxxx;
                    for (int s = 1; s >= 0; s--) begin
                        isb[s] = t[s] && (op[s] == 2'd1 || op[s] == 2'd2);
                        isr[s] = t[s] && (op[s] == 2'd3);
                        tg[s]  = (op[s] == 2'd2) ? rv[s] : bdisp(base, im[s]);
                        if (isb[s]) begin
                            nb++;
                            efc = tg[s];
                        end
                        if (isr[s]) edst = rdisp(base, im[s][6:0]);
                    end
                    pkt_base = base;
                    slot_op = {op[1], op[0]};
                    slot_taken = 2'(t);
                    slot_imm = {im[1], im[0]};
                    slot_reg = {rv[1], rv[0]};
                    step(1'b1);
                    chk("R1/R2/R7 redirect", {31'b0, redirect}, {31'b0, nb > 0});
                    chk("R1/R2/R7/R8 fetch_ctr", fetch_ctr, efc);
                    chk("R8 dual_br", {31'b0, dual_br}, {31'b0, nb > 1});
                    chk("R3/R7 dst_wr", {31'b0, dst_wr}, {31'b0, isr[0] || isr[1]});
                    if (isr[0] || isr[1]) chk("R3 dst_val", dst_val, edst);
                    chk("R4 no stall for zero count", {31'b0, stall}, 32'h0);
                    fc_prev = efc;
                end
            end
        end

        // R10 idle cycle keeps the counter and clears pulses
        step(1'b0);
        chk("R10 fetch_ctr held", fetch_ctr, fc_prev);
        chk("R10 redirect idle", {31'b0, redirect}, 32'h0);

        // R1 R6 displacement extremes and strided walk, base with low bits set
        for (int k = 0; k < 520; k++) begin
            logic [20:0] d;
            logic [31:0] base;
            case (k)
                0: d = 21'h000000;
                1: d = 21'h0FFFFF;
                2: d = 21'h100000;
                3: d = 21'h1FFFFF;
                default: d = 21'(k * 4099);
            endcase
            base = 32'h4000_0000 + 32'(k * 544) + 32'(k % 32);
            pkt_base = base;
            slot_op = 4'b0001;
            slot_taken = 2'b01;
            slot_imm = {21'h0, d};
            step(1'b1);
            chk("R1/R6 disp target", fetch_ctr, bdisp(base, d));
            fc_prev = bdisp(base, d);
        end

        // R3 R6 every return offset, count 0
        for (int k = 0; k < 128; k++) begin
            logic [31:0] base;
            base = 32'h8000_0000 + 32'(k * 32) + 32'(31 - (k % 32));
            pkt_base = base;
            slot_op = 4'b1100;
            slot_taken = 2'b10;
            slot_imm = {11'h0, 3'd0, 7'(k), 21'h0};
            step(1'b1);
            chk("R3/R6 dst_val", dst_val, rdisp(base, 7'(k)));
            chk("R3 dst_wr", {31'b0, dst_wr}, 32'h1);
            chk("R10 fetch unchanged", fetch_ctr, fc_prev);
        end

        // R4 R5 every count; packets offered during stall must be ignored
        for (int n = 0; n < 8; n++) begin
            pkt_base = 32'h0000_2000;
            slot_op = 4'b0011;
            slot_taken = 2'b01;
            slot_imm = {21'h0, 11'h0, 3'(n), 7'h01};
            step(1'b1);
            chk("R3 dst_wr with count", {31'b0, dst_wr}, 32'h1);
            for (int k = 0; k < 9; k++) begin
                chk("R4 stall length", {31'b0, stall}, {31'b0, k < n});
                chk("R5 no redirect", {31'b0, redirect}, 32'h0);
                if (k > 0) chk("R5 no dst_wr", {31'b0, dst_wr}, 32'h0);
                chk("R5 fetch held", fetch_ctr, fc_prev);
                slot_op = 4'b1110;
                slot_taken = 2'b11;
                slot_reg = {32'hDEAD_0000, 32'hCAFE_0000};
                step(stall);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule